// File: doc/BRIEF.md
# Receive Elastic Buffer with Idle-Based Clock Correction

This block moves decoded receive characters from the recovered receive clock into the local system clock on a gigabit ten-bit-interface path. Each stored entry holds one character: an 8-bit value, a flag that marks it as a control character, and a flag that marks it as part of a frame. The two clocks are nominally equal but may differ by a small tolerance. The buffer absorbs that difference in a 32-entry store. Read and write positions cross between the domains as Gray-coded pointers through two-flop synchronizers.

Between frames the buffer keeps its fill level near the middle of the store. It does this only on idle ordered sets, which are a K28.5 comma (control flag set, value 0xBC) followed by one data character. When the level is high, the write side drops a whole set. When the level is low, the read side emits a set a second time. Inside a frame nothing is changed. If the fill level reaches a hard limit, the block raises a sticky error flag and brings the level back to the middle of the band.

The write side runs three states. PASS stores characters. SKIP drops the second character of a removed set. HALT drops characters after an overflow until the level is back at the centre. Its transitions are PASS to SKIP (drop a set), SKIP to PASS, PASS to HALT (overflow) and HALT to PASS (recentred).

The read side runs four states. FILL holds the output off. RUN emits stored characters. REPK replays the comma and REPD replays the saved data character. Its transitions are FILL to RUN (level reached 16), RUN to FILL (underflow), RUN to REPK (insert a set), REPK to REPD and REPD to RUN.

Top module: `ebuf_top`

## Requirements
- R1: After reset, r_valid, r_unf and w_ovf are 0 and r_occ reads 0.
- R2: After reset, r_valid stays 0 until the read-side occupancy has reached 16 entries.
- R3: Characters with w_frame=1 come out with r_frame=1, in order, with the same value and control flag, with none dropped or added, as long as no error flag is raised.
- R4: When a comma (w_ctrl=1, w_char=0xBC, w_frame=0) arrives while the write-side occupancy is above 18, that comma and the character after it are not stored.
- R5: When the read side has just emitted a non-frame comma and is emitting a non-frame data character (ctrl=0) while its occupancy is below 14, it emits that comma and data character once more.
- R6: On the output, a non-frame comma is always followed by a non-frame data character.
- R7: When the write-side occupancy reaches 30, w_ovf is set. Incoming characters are then dropped until the occupancy is 16 or less.
- R8: When the read-side occupancy is 2 or less in the running state, r_unf is set. r_valid then goes to 0 until the occupancy has reached 16 again.
- R9: w_ovf and r_unf stay set until a one-cycle pulse on w_clr or r_clr, respectively, clears them. A new error in the same cycle as a clear wins.
- R10: r_occ gives the read-domain occupancy in entries and never exceeds 32. Between frames at steady state it settles near the 14 to 18 band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered receive clock |
| wrst_n | input | 1 | Active-low asynchronous reset, write domain |
| w_char | input | 8 | Incoming decoded character |
| w_ctrl | input | 1 | Incoming character is a control character |
| w_frame | input | 1 | Incoming character belongs to a frame |
| w_clr | input | 1 | Clears w_ovf |
| w_ovf | output | 1 | Sticky overflow flag, write domain |
| rclk | input | 1 | Local system clock |
| rrst_n | input | 1 | Active-low asynchronous reset, read domain |
| r_clr | input | 1 | Clears r_unf |
| r_valid | output | 1 | Output character is valid |
| r_char | output | 8 | Output character |
| r_ctrl | output | 1 | Output character is a control character |
| r_frame | output | 1 | Output character belongs to a frame |
| r_unf | output | 1 | Sticky underflow flag, read domain |
| r_occ | output | 6 | Read-domain occupancy in entries |

## Verification
Clock correction and frame transfer can fall on the same character boundary. This happens when a removal or repeat decision lands on the idle set that sits directly in front of a frame's first character. The bench provokes it by placing frames right behind idle pairs while the write clock runs 3% fast and then 3% slow. This forces many removals and repeats next to frame starts. A scoreboard then confirms that every frame character still arrives once, in order, and that the idle sets around it stay intact.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
    localparam int CHAR_W = 8;
    localparam logic [CHAR_W-1:0] COMMA_CODE = 8'hBC;

    typedef struct packed {
        logic              frame;
        logic              ctrl;
        logic [CHAR_W-1:0] data;
    } ebuf_ent_t;

    typedef enum logic [1:0] {W_PASS, W_SKIP, W_HALT} wr_state_t;
    typedef enum logic [1:0] {R_FILL, R_RUN, R_REPK, R_REPD} rd_state_t;
endpackage

// File: rtl/ebuf_sync.sv
module ebuf_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n)
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n)
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ebuf_store.sv
module ebuf_store #(
    parameter int AW = 5
) (
    input  logic                wclk,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  ebuf_pkg::ebuf_ent_t wdata,
    input  logic [AW-1:0]       raddr,
    output ebuf_pkg::ebuf_ent_t rdata
);
    localparam int DEPTH = 1 << AW;

    ebuf_pkg::ebuf_ent_t mem [DEPTH];

    always_ff @(posedge wclk)
        if (we) mem[waddr] <= wdata;

    assign rdata = mem[raddr];
endmodule

// File: rtl/ebuf_wr.sv
module ebuf_wr
    import ebuf_pkg::*;
#(
    parameter int AW       = 5,
    parameter int HI_MARK  = 18,
    parameter int OVF_MARK = 30,
    parameter int MID_MARK = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              in_ctrl,
    input  logic              in_frame,
    input  logic              clr,
    input  logic [AW:0]       rgray_s,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output ebuf_ent_t         wdata,
    output logic [AW:0]       wgray,
    output logic              ovf,
    output logic [AW:0]       occ
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] HI_L  = PW'(HI_MARK);
    localparam logic [PW-1:0] OVF_L = PW'(OVF_MARK);
    localparam logic [PW-1:0] MID_L = PW'(MID_MARK);

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wr_state_t     st, st_nx;
    logic [PW-1:0] wbin, wbin_nx, rbin_s;
    logic          idle_comma, set_ovf;

    assign rbin_s     = g2b(rgray_s);
    assign occ        = wbin - rbin_s;
    assign idle_comma = in_ctrl && !in_frame && (in_char == COMMA_CODE);
    assign wbin_nx    = wbin + {{(PW-1){1'b0}}, we};
    assign waddr      = wbin[AW-1:0];
    assign wdata      = '{frame: in_frame, ctrl: in_ctrl, data: in_char};

    always_comb begin
        st_nx   = st;
        we      = 1'b0;
        set_ovf = 1'b0;
        unique case (st)
            W_PASS: begin
                if (occ >= OVF_L) begin
                    st_nx   = W_HALT;
                    set_ovf = 1'b1;
                end else if (idle_comma && occ > HI_L) begin
                    st_nx = W_SKIP;
                end else begin
                    we = 1'b1;
                end
            end
            W_SKIP: st_nx = W_PASS;
            W_HALT: if (occ <= MID_L) st_nx = W_PASS;
            default: st_nx = W_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st <= W_PASS;
        else        st <= st_nx;

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            ovf   <= 1'b0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
            if (set_ovf)  ovf <= 1'b1;
            else if (clr) ovf <= 1'b0;
        end
endmodule

// File: rtl/ebuf_rd.sv
module ebuf_rd
    import ebuf_pkg::*;
#(
    parameter int AW       = 5,
    parameter int LO_MARK  = 14,
    parameter int UNF_MARK = 2,
    parameter int MID_MARK = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW:0]   wgray_s,
    input  ebuf_ent_t     rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          out_valid,
    output ebuf_ent_t     out_ent,
    output logic          unf,
    output logic [AW:0]   occ
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] LO_L  = PW'(LO_MARK);
    localparam logic [PW-1:0] UNF_L = PW'(UNF_MARK);
    localparam logic [PW-1:0] MID_L = PW'(MID_MARK);

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    rd_state_t     st, st_nx;
    logic [PW-1:0] rbin, rbin_nx, wbin_s;
    logic          adv, emit, set_unf, last_comma, idle_data;
    ebuf_ent_t     emit_ent, saved;

    assign wbin_s    = g2b(wgray_s);
    assign occ       = wbin_s - rbin;
    assign raddr     = rbin[AW-1:0];
    assign rbin_nx   = rbin + {{(PW-1){1'b0}}, adv};
    assign idle_data = !rdata.frame && !rdata.ctrl;

    always_comb begin
        st_nx    = st;
        adv      = 1'b0;
        emit     = 1'b0;
        set_unf  = 1'b0;
        emit_ent = rdata;
        unique case (st)
            R_FILL: if (occ >= MID_L) st_nx = R_RUN;
            R_RUN: begin
                if (occ <= UNF_L) begin
                    st_nx   = R_FILL;
                    set_unf = 1'b1;
                end else begin
                    adv  = 1'b1;
                    emit = 1'b1;
                    if (idle_data && last_comma && occ < LO_L) st_nx = R_REPK;
                end
            end
            R_REPK: begin
                emit     = 1'b1;
                emit_ent = '{frame: 1'b0, ctrl: 1'b1, data: COMMA_CODE};
                st_nx    = R_REPD;
            end
            R_REPD: begin
                emit     = 1'b1;
                emit_ent = saved;
                st_nx    = R_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st <= R_FILL;
        else        st <= st_nx;

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
            rbin       <= '0;
            rgray      <= '0;
            out_valid  <= 1'b0;
            out_ent    <= '0;
            saved      <= '0;
            last_comma <= 1'b0;
            unf        <= 1'b0;
        end else begin
            rbin      <= rbin_nx;
            rgray     <= rbin_nx ^ (rbin_nx >> 1);
            out_valid <= emit;
            if (emit) begin
                out_ent    <= emit_ent;
                last_comma <= !emit_ent.frame && emit_ent.ctrl &&
                              (emit_ent.data == COMMA_CODE);
            end
            if (adv)          saved <= rdata;
            if (set_unf)      unf <= 1'b1;
            else if (clr)     unf <= 1'b0;
        end
endmodule

// File: rtl/ebuf_top.sv
module ebuf_top #(
    parameter int ADDR_W      = 5,
    parameter int HI_MARK     = 18,
    parameter int LO_MARK     = 14,
    parameter int OVF_MARK    = 30,
    parameter int UNF_MARK    = 2,
    parameter int MID_MARK    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       wclk,
    input  logic       wrst_n,
    input  logic [7:0] w_char,
    input  logic       w_ctrl,
    input  logic       w_frame,
    input  logic       w_clr,
    output logic       w_ovf,
    input  logic       rclk,
    input  logic       rrst_n,
    input  logic       r_clr,
    output logic       r_valid,
    output logic [7:0] r_char,
    output logic       r_ctrl,
    output logic       r_frame,
    output logic       r_unf,
    output logic [5:0] r_occ
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic                we;
    logic [ADDR_W-1:0]   waddr, raddr;
    ebuf_pkg::ebuf_ent_t wdata, rdata, out_ent;
    logic [PW-1:0]       wgray, rgray, wgray_s, rgray_s, wr_occ, rd_occ;

    ebuf_store #(.AW(ADDR_W)) u_store (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    ebuf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
    );

    ebuf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
    );

    ebuf_wr #(.AW(ADDR_W), .HI_MARK(HI_MARK), .OVF_MARK(OVF_MARK),
              .MID_MARK(MID_MARK)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .in_char(w_char), .in_ctrl(w_ctrl),
        .in_frame(w_frame), .clr(w_clr), .rgray_s(rgray_s), .we(we),
        .waddr(waddr), .wdata(wdata), .wgray(wgray), .ovf(w_ovf),
        .occ(wr_occ)
    );

    ebuf_rd #(.AW(ADDR_W), .LO_MARK(LO_MARK), .UNF_MARK(UNF_MARK),
              .MID_MARK(MID_MARK)) u_rd (
        .clk(rclk), .rst_n(rrst_n), .clr(r_clr), .wgray_s(wgray_s),
        .rdata(rdata), .raddr(raddr), .rgray(rgray), .out_valid(r_valid),
        .out_ent(out_ent), .unf(r_unf), .occ(rd_occ)
    );

    assign r_char  = out_ent.data;
    assign r_ctrl  = out_ent.ctrl;
    assign r_frame = out_ent.frame;
    assign r_occ   = 6'(rd_occ);
endmodule

// File: rtl/ebuf_chk.sv
module ebuf_chk #(
    parameter int PW    = 6,
    parameter int DEPTH = 32
) (
    input logic          wclk,
    input logic          wrst_n,
    input logic          rclk,
    input logic          rrst_n,
    input logic          w_clr,
    input logic          w_ovf,
    input logic          r_clr,
    input logic          r_unf,
    input logic          r_valid,
    input logic [5:0]    r_occ,
    input logic [PW-1:0] wr_occ
);
    AST_OCC_CAP: assert property (@(posedge rclk) disable iff (!rrst_n)
        int'(r_occ) <= DEPTH); // R10
    AST_WR_CAP: assert property (@(posedge wclk) disable iff (!wrst_n)
        int'(wr_occ) <= DEPTH); // R7
    AST_UNF_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
        $rose(r_unf) |-> !r_valid); // R8
    AST_UNF_STICKY: assert property (@(posedge rclk) disable iff (!rrst_n)
        (r_unf && !r_clr) |=> r_unf); // R9
    AST_OVF_STICKY: assert property (@(posedge wclk) disable iff (!wrst_n)
        (w_ovf && !w_clr) |=> w_ovf); // R9
endmodule

bind ebuf_top ebuf_chk #(.PW(PW), .DEPTH(DEPTH)) u_chk (
    .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
    .w_clr(w_clr), .w_ovf(w_ovf), .r_clr(r_clr), .r_unf(r_unf),
    .r_valid(r_valid), .r_occ(r_occ), .wr_occ(wr_occ)
);

// File: tb/sim_ebuf_top.sv
`timescale 1ns/1ps
module sim_ebuf_top;
    logic       wclk = 1'b0, rclk = 1'b0;
    logic       wrst_n = 1'b0, rrst_n = 1'b0;
    logic [7:0] w_char = 8'h50;
    logic       w_ctrl = 1'b0, w_frame = 1'b0, w_clr = 1'b0, r_clr = 1'b0;
    logic       w_ovf, r_valid, r_ctrl, r_frame, r_unf;
    logic [7:0] r_char;
    logic [5:0] r_occ;

    realtime whalf = 10.0;
    always #(whalf) wclk = ~wclk;
    always #10 rclk = ~rclk;

    ebuf_top u0 (
        .wclk(wclk), .wrst_n(wrst_n), .w_char(w_char), .w_ctrl(w_ctrl),
        .w_frame(w_frame), .w_clr(w_clr), .w_ovf(w_ovf), .rclk(rclk),
        .rrst_n(rrst_n), .r_clr(r_clr), .r_valid(r_valid), .r_char(r_char),
        .r_ctrl(r_ctrl), .r_frame(r_frame), .r_unf(r_unf), .r_occ(r_occ)
    );

    int n_chk = 0, n_fail = 0;
    int in_idle = 0, out_idle = 0, unf_hold = 0, prev_occ = 0;
    bit sb_on = 1'b1, seen_valid = 1'b0, prev_comma = 1'b0;
    logic [8:0] sb_q [$];
    logic [7:0] seed = 8'h1D;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_char(input bit fr, input bit ct, input logic [7:0] ch);
        @(negedge wclk);
        w_frame = fr; w_ctrl = ct; w_char = ch;
        if (!fr) in_idle++;
        if (fr && sb_on) sb_q.push_back({ct, ch});
    endtask

    task automatic send_idle(input int pairs);
        for (int i = 0; i < pairs; i++) begin
            send_char(1'b0, 1'b1, 8'hBC);
            send_char(1'b0, 1'b0, 8'h50);
        end
    endtask

    task automatic send_frame(input int len);
        for (int i = 0; i < len; i++) begin
            seed = {seed[6:0], seed[7] ^ seed[5] ^ seed[4] ^ seed[3]};
            send_char(1'b1, (i % 17) == 5, seed);
        end
    endtask

    // Monitor: scoreboard pop and idle-structure checks
    always @(negedge rclk) begin
        if (rrst_n) begin
            if (!seen_valid && r_valid) begin
                seen_valid = 1'b1;
                chk(prev_occ >= 16, "R2", "occupancy before first output", prev_occ, 16);
            end
            if (r_unf && !r_valid) unf_hold++;
            if (r_valid) begin
                if (!r_frame) out_idle++;
                if (sb_on && prev_comma)
                    chk(!r_frame && !r_ctrl, "R6", "char after idle comma {frame,ctrl}",
                        int'({r_frame, r_ctrl}), 0);
                prev_comma = !r_frame && r_ctrl && (r_char == 8'hBC);
                if (sb_on && r_frame) begin
                    if (sb_q.size() == 0)
                        chk(1'b0, "R3", "unexpected frame char", int'(r_char), -1);
                    else begin
                        logic [8:0] e;
                        e = sb_q.pop_front();
                        chk({r_ctrl, r_char} == e, "R3", "frame char {ctrl,char}",
                            int'({r_ctrl, r_char}), int'(e));
                    end
                end
            end
            prev_occ = int'(r_occ);
        end
    end

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        #3_000_000;
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int i0, o0;
        #95 wrst_n = 1'b1; rrst_n = 1'b1;
        #1;
        chk(r_valid == 1'b0, "R1", "r_valid after reset", int'(r_valid), 0);
        chk(r_unf == 1'b0, "R1", "r_unf after reset", int'(r_unf), 0);
        chk(w_ovf == 1'b0, "R1", "w_ovf after reset", int'(w_ovf), 0);
        chk(r_occ == 6'd0, "R1", "r_occ after reset", int'(r_occ), 0);

        send_idle(40);
        for (int k = 0; k < 5; k++) begin send_frame(50); send_idle(8); end

        // R4: write clock 3% fast, idle sets must be removed
        whalf = 9.7;
        i0 = in_idle; o0 = out_idle;
        for (int k = 0; k < 50; k++) begin send_frame(60); send_idle(6); end
        chk((in_idle - i0) - (out_idle - o0) >= 60, "R4", "idle chars removed",
            (in_idle - i0) - (out_idle - o0), 60);
        chk(w_ovf == 1'b0, "R4", "no overflow while removing", int'(w_ovf), 0);
        chk(int'(r_occ) >= 10 && int'(r_occ) <= 24, "R10", "occupancy near band (fast)",
            int'(r_occ), 18);

        // R5: write clock 3% slow, idle sets must be repeated
        whalf = 10.3;
        i0 = in_idle; o0 = out_idle;
        for (int k = 0; k < 50; k++) begin send_frame(60); send_idle(6); end
        chk((out_idle - o0) - (in_idle - i0) >= 60, "R5", "idle chars inserted",
            (out_idle - o0) - (in_idle - i0), 60);
        chk(r_unf == 1'b0, "R5", "no underflow while inserting", int'(r_unf), 0);
        chk(int'(r_occ) >= 8 && int'(r_occ) <= 22, "R10", "occupancy near band (slow)",
            int'(r_occ), 14);

        whalf = 10.0;
        send_idle(60);
        chk(sb_q.size() == 0, "R3", "scoreboard drained", sb_q.size(), 0);

        // R7: overflow inside a long frame
        sb_on = 1'b0;
        whalf = 7.0;
        send_frame(300);
        @(negedge wclk);
        chk(w_ovf == 1'b1, "R7", "w_ovf after fast frame", int'(w_ovf), 1);
        whalf = 10.0;
        send_idle(40);
        chk(w_ovf == 1'b1, "R9", "w_ovf sticky", int'(w_ovf), 1);
        chk(int'(r_occ) >= 8 && int'(r_occ) <= 24, "R7", "occupancy recentred",
            int'(r_occ), 16);
        @(negedge wclk); w_clr = 1'b1;
        @(negedge wclk); w_clr = 1'b0;
        @(negedge wclk);
        chk(w_ovf == 1'b0, "R9", "w_ovf cleared", int'(w_ovf), 0);

        // R8: underflow inside a long frame
        whalf = 14.0;
        send_frame(300);
        @(negedge rclk);
        chk(r_unf == 1'b1, "R8", "r_unf after slow frame", int'(r_unf), 1);
        chk(unf_hold > 0, "R8", "output held after underflow", unf_hold, 1);
        whalf = 10.0;
        send_idle(40);
        chk(r_unf == 1'b1, "R9", "r_unf sticky", int'(r_unf), 1);
        @(negedge rclk); r_clr = 1'b1;
        @(negedge rclk); r_clr = 1'b0;
        @(negedge rclk);
        chk(r_unf == 1'b0, "R9", "r_unf cleared", int'(r_unf), 0);

        // R3: clean frames again with mild drift both ways
        send_idle(60);
        @(negedge rclk);
        #1;
        sb_q.delete();
        prev_comma = 1'b0;
        sb_on = 1'b1;
        for (int k = 0; k < 6; k++) begin
            whalf = (k % 2 == 0) ? 9.9 : 10.1;
            send_frame(40);
            send_idle(6);
        end
        whalf = 10.0;
        send_idle(60);
        chk(sb_q.size() == 0, "R3", "final scoreboard drained", sb_q.size(), 0);
        chk(w_ovf == 1'b0 && r_unf == 1'b0, "R3", "no error flags",
            int'({w_ovf, r_unf}), 0);
        chk(int'(r_occ) >= 10 && int'(r_occ) <= 22, "R10", "final occupancy",
            int'(r_occ), 16);

        summary();
        $finish;
    end
endmodule